// File: doc/BRIEF.md
# Bidirectional Registered Bus Transceiver

This block moves data between two bidirectional ports, A and B, through a pair of storage elements, one for each direction. It is split into independent groups (two groups of 18 bits by default). Each group has six controls: for each direction an output enable, a latch enable and a capture clock. While a direction's latch enable is high its storage is transparent and the far port follows the near port. While the latch enable is low the storage keeps its contents, except that a rising edge on that direction's capture clock loads the current near-port data. The A-to-B output enable is active high. The B-to-A output enable is active low.

Each bidirectional pin is split into three signals: an external-driver value with a per-group driver-present flag, the block's own output value with a per-group drive flag, and a resolved bus value. A bus-hold stage per port and group resolves the bus. An external driver takes priority, then the block's own drive. When nothing drives the bus it keeps its last level. The source data for each direction is the resolved bus value of its near port.

All controls and data run on a fast system clock. Every input is registered once. Edges on the capture clocks are detected by comparing consecutive samples. A change at the inputs reaches the storage, the output enables and the resolved bus values two system clock cycles later.

Top module: `bidir_reg_xcvr`

## Requirements
- R1: With a direction's latch enable high, its output (b_out for A-to-B, a_out for B-to-A) equals the resolved near-port value sampled two clock cycles earlier, and it follows every change with that same latency.
- R2: With a direction's latch enable low and its capture clock steady, either high or low, the stored value and the output do not change, whatever the near-port data does.
- R3: With a direction's latch enable low, a low sample followed by a high sample of its capture clock loads the near-port data present with the high sample. The output shows the loaded value one cycle after the edge is detected.
- R4: b_out_en follows the A-to-B enable ab_oe (1 = drive), delayed by two cycles. While it is 0 the storage still updates, and the stored value appears once the enable returns.
- R5: a_out_en follows the inverse of ba_oe_n (0 = drive), delayed by two cycles. The B-to-A path otherwise behaves as in R1 to R3 with its own latch enable and capture clock.
- R6: A falling capture clock with the latch enable low loads nothing. When the latch enable falls while the capture clock is low, the value held is the one passed through during the last transparent cycle.
- R7: Group g (bits g*18 to g*18+17 of every data vector, bit g of every control vector) responds only to its own controls. Other groups' stores and enables are unaffected.
- R8: The resolved bus value (a_bus, b_bus) is the external value when the driver-present flag is 1, otherwise the block's own output when its drive flag is 1, otherwise the previous resolved value.
- R9: Reset clears both stores and both bus-hold values to zero and disables both outputs. A capture clock that is already high when reset ends is not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ab_oe | input | GROUPS | A-to-B output enable per group, active high |
| ba_oe_n | input | GROUPS | B-to-A output enable per group, active low |
| ab_le | input | GROUPS | A-to-B latch enable per group |
| ba_le | input | GROUPS | B-to-A latch enable per group |
| ab_ck | input | GROUPS | A-to-B capture clock per group |
| ba_ck | input | GROUPS | B-to-A capture clock per group |
| a_in | input | GROUPS*WIDTH | Value driven onto port A by an external driver |
| a_in_en | input | GROUPS | External driver present on port A, per group |
| b_in | input | GROUPS*WIDTH | Value driven onto port B by an external driver |
| b_in_en | input | GROUPS | External driver present on port B, per group |
| a_out | output | GROUPS*WIDTH | Block's B-to-A drive value onto port A |
| a_out_en | output | GROUPS | Block drives port A, per group |
| b_out | output | GROUPS*WIDTH | Block's A-to-B drive value onto port B |
| b_out_en | output | GROUPS | Block drives port B, per group |
| a_bus | output | GROUPS*WIDTH | Resolved port A level including bus hold |
| b_bus | output | GROUPS*WIDTH | Resolved port B level including bus hold |

## Verification
The assertions assume that each capture clock and latch enable stays at one level for at least one system cycle. That way a capture edge shows up as a single low-to-high pair of samples. The reference model in the bench takes a capture to load a settled value. For that reason the stimulus only requests a capture while the near port is driven externally, and it holds every input pattern for five cycles so that transparent paths feeding back through the bus-hold stage settle before any output is compared. Corner cases get directed tests: the two-cycle latency, a capture clock that is already high when reset is released, and group-specific control patterns.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        XM_HOLD    = 2'd0,
        XM_PASS    = 2'd1,
        XM_CAPTURE = 2'd2
    } xfer_mode_e;

    // Chooses how a direction's storage behaves this cycle.
    function automatic xfer_mode_e pick_mode(input logic le, input logic ck,
                                             input logic ck_prev, input logic primed);
        xfer_mode_e m;
        if (le)
            m = XM_PASS;
        else if (primed && ck && !ck_prev)
            m = XM_CAPTURE;
        else
            m = XM_HOLD;
        return m;
    endfunction

endpackage

// File: rtl/xcvr_sync.sv
module xcvr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic         vld
);

    typedef struct packed {
        logic [W-1:0] smp;
        logic         vld;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.smp = d;
        st_d.vld = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q   = st_q.smp;
    assign vld = st_q.vld;

endmodule

// File: rtl/xcvr_dir.sv
module xcvr_dir
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         vld,
    input  logic         oe,
    input  logic         le,
    input  logic         ck,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         dout_en
);

    typedef struct packed {
        logic [W-1:0] store;
        logic         en;
        logic         ck_prev;
        logic         primed;
    } dir_t;

    dir_t       st_d, st_q;
    xfer_mode_e mode;

    always_comb begin
        mode         = pick_mode(le, ck, st_q.ck_prev, st_q.primed);
        st_d         = st_q;
        st_d.en      = oe;
        st_d.ck_prev = ck;
        st_d.primed  = vld;
        case (mode)
            XM_PASS, XM_CAPTURE: st_d.store = din;
            default:             st_d.store = st_q.store;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout    = st_q.store;
    assign dout_en = st_q.en;

    a_r1_transparent: assert property (@(posedge clk) disable iff (!rst_n)
        le |=> dout == $past(din));

    a_r2_low_clock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!le && !ck) |=> $stable(dout));

    a_r3_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && $past(vld) && !le && ck && !$past(ck)) |=> dout == $past(din));

    a_r4_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        oe |=> dout_en);

    a_r4_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |=> !dout_en);

endmodule

// File: rtl/xcvr_hold.sv
module xcvr_hold #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ext_en,
    input  logic [W-1:0] ext,
    input  logic         own_en,
    input  logic [W-1:0] own,
    output logic [W-1:0] seen,
    output logic [W-1:0] bus
);

    typedef struct packed {
        logic [W-1:0] level;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        if (ext_en)      seen = ext;
        else if (own_en) seen = own;
        else             seen = st_q.level;
        st_d       = st_q;
        st_d.level = seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus = st_q.level;

    a_r8_float_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && !own_en) |=> $stable(bus));

    a_r8_external_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ext_en |=> bus == $past(ext));

    a_r8_own_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_en && own_en) |=> bus == $past(own));

endmodule

// File: rtl/bidir_reg_xcvr.sv
module bidir_reg_xcvr #(
    parameter int GROUPS = 2,
    parameter int WIDTH  = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [GROUPS-1:0]         ab_oe,
    input  logic [GROUPS-1:0]         ba_oe_n,
    input  logic [GROUPS-1:0]         ab_le,
    input  logic [GROUPS-1:0]         ba_le,
    input  logic [GROUPS-1:0]         ab_ck,
    input  logic [GROUPS-1:0]         ba_ck,
    input  logic [GROUPS*WIDTH-1:0]   a_in,
    input  logic [GROUPS-1:0]         a_in_en,
    input  logic [GROUPS*WIDTH-1:0]   b_in,
    input  logic [GROUPS-1:0]         b_in_en,
    output logic [GROUPS*WIDTH-1:0]   a_out,
    output logic [GROUPS-1:0]         a_out_en,
    output logic [GROUPS*WIDTH-1:0]   b_out,
    output logic [GROUPS-1:0]         b_out_en,
    output logic [GROUPS*WIDTH-1:0]   a_bus,
    output logic [GROUPS*WIDTH-1:0]   b_bus
);

    localparam int N      = GROUPS * WIDTH;
    localparam int CTL_W  = 8 * GROUPS;
    localparam int SYNC_W = CTL_W + 2 * N;

    logic [SYNC_W-1:0] raw, smp;
    logic              smp_vld;

    logic [GROUPS-1:0] ab_oe_s, ba_oe_s, ab_le_s, ba_le_s, ab_ck_s, ba_ck_s;
    logic [GROUPS-1:0] a_en_s, b_en_s;
    logic [N-1:0]      a_in_s, b_in_s;
    logic [N-1:0]      a_seen, b_seen;

    // The B-to-A enable is inverted before sampling, so a reset value of zero means disabled.
    assign raw = {ab_oe, ~ba_oe_n, ab_le, ba_le, ab_ck, ba_ck, a_in_en, b_in_en, a_in, b_in};

    xcvr_sync #(.W(SYNC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (raw),
        .q    (smp),
        .vld  (smp_vld)
    );

    assign {ab_oe_s, ba_oe_s, ab_le_s, ba_le_s, ab_ck_s, ba_ck_s,
            a_en_s, b_en_s, a_in_s, b_in_s} = smp;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        xcvr_hold #(.W(WIDTH)) u_hold_a (
            .clk   (clk),
            .rst_n (rst_n),
            .ext_en(a_en_s[g]),
            .ext   (a_in_s[g*WIDTH +: WIDTH]),
            .own_en(a_out_en[g]),
            .own   (a_out[g*WIDTH +: WIDTH]),
            .seen  (a_seen[g*WIDTH +: WIDTH]),
            .bus   (a_bus[g*WIDTH +: WIDTH])
        );

        xcvr_hold #(.W(WIDTH)) u_hold_b (
            .clk   (clk),
            .rst_n (rst_n),
            .ext_en(b_en_s[g]),
            .ext   (b_in_s[g*WIDTH +: WIDTH]),
            .own_en(b_out_en[g]),
            .own   (b_out[g*WIDTH +: WIDTH]),
            .seen  (b_seen[g*WIDTH +: WIDTH]),
            .bus   (b_bus[g*WIDTH +: WIDTH])
        );

        xcvr_dir #(.W(WIDTH)) u_ab (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (smp_vld),
            .oe     (ab_oe_s[g]),
            .le     (ab_le_s[g]),
            .ck     (ab_ck_s[g]),
            .din    (a_seen[g*WIDTH +: WIDTH]),
            .dout   (b_out[g*WIDTH +: WIDTH]),
            .dout_en(b_out_en[g])
        );

        xcvr_dir #(.W(WIDTH)) u_ba (
            .clk    (clk),
            .rst_n  (rst_n),
            .vld    (smp_vld),
            .oe     (ba_oe_s[g]),
            .le     (ba_le_s[g]),
            .ck     (ba_ck_s[g]),
            .din    (b_seen[g*WIDTH +: WIDTH]),
            .dout   (a_out[g*WIDTH +: WIDTH]),
            .dout_en(a_out_en[g])
        );
    end

    // R9: the first sampled cycle after reset never drives either port.
    a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> (a_out_en == '0) && (b_out_en == '0));

endmodule

// File: tb/sim_bidir_reg_xcvr.sv
`timescale 1ns/1ps
module sim_bidir_reg_xcvr;

    localparam int G = 2;
    localparam int W = 18;
    localparam int N = G * W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [G-1:0] ab_oe = '0, ba_oe_n = '1, ab_le = '0, ba_le = '0, ab_ck = '0, ba_ck = '0;
    logic [G-1:0] a_in_en = '0, b_in_en = '0;
    logic [N-1:0] a_in = '0, b_in = '0;
    logic [N-1:0] a_out, b_out, a_bus, b_bus;
    logic [G-1:0] a_out_en, b_out_en;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    bidir_reg_xcvr #(.GROUPS(G), .WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .ab_oe(ab_oe), .ba_oe_n(ba_oe_n), .ab_le(ab_le), .ba_le(ba_le),
        .ab_ck(ab_ck), .ba_ck(ba_ck),
        .a_in(a_in), .a_in_en(a_in_en), .b_in(b_in), .b_in_en(b_in_en),
        .a_out(a_out), .a_out_en(a_out_en), .b_out(b_out), .b_out_en(b_out_en),
        .a_bus(a_bus), .b_bus(b_bus)
    );

    typedef struct packed {
        logic [1:0]  oab, oban, lab, lba, cab, cba, aen, ben;
        logic [35:0] a, b;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'h1_2345_6789, 36'h0},
        '{2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'h9_A5C3_0F1E, 36'h0},
        '{2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'h4_4444_BBBB, 36'h0},
        '{2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 36'h4_4444_BBBB, 36'h0},
        '{2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 36'h7_0F0F_1234, 36'h0},
        '{2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'h3_C0DE_5A5A, 36'h0},
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'h3_C0DE_5A5A, 36'h0},
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 36'hE_1357_2468, 36'h0},
        '{2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'h0_0000_0001, 36'h0},
        '{2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 36'h0, 36'h8_BEEF_7531},
        '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 36'h0, 36'h2_DEAD_0000},
        '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 36'h0, 36'h2_DEAD_0000},
        '{2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 36'h0, 36'h0},
        '{2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 36'h0, 36'h0},
        '{2'b11, 2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'h5_6789_ABCD, 36'h0},
        '{2'b11, 2'b11, 2'b00, 2'b00, 2'b10, 2'b00, 2'b11, 2'b00, 36'hF_0000_FFFF, 36'h0}
    };

    // Reference state per group: stores, bus-hold levels, previous capture clocks.
    logic [W-1:0] m_sa [G];
    logic [W-1:0] m_sb [G];
    logic [W-1:0] m_ha [G];
    logic [W-1:0] m_hb [G];
    logic         m_cpa [G];
    logic         m_cpb [G];

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        ab_oe = v.oab; ba_oe_n = v.oban; ab_le = v.lab; ba_le = v.lba;
        ab_ck = v.cab; ba_ck = v.cba; a_in_en = v.aen; b_in_en = v.ben;
        a_in = v.a; b_in = v.b;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [W-1:0] ai, bi, ar, br, sa, sb;
        logic ea, eb;
        for (int g = 0; g < G; g++) begin
            m_sa[g] = '0; m_sb[g] = '0; m_ha[g] = '0; m_hb[g] = '0;
            m_cpa[g] = 1'b0; m_cpb[g] = 1'b0;
        end

        // R9: reset state
        repeat (3) @(negedge clk);
        chk("R9 reset a_out_en", {34'h0, a_out_en}, 36'h0);
        chk("R9 reset b_out_en", {34'h0, b_out_en}, 36'h0);
        rst_n = 1'b1;
        settle();
        chk("R9 idle a_bus", a_bus, 36'h0);
        chk("R9 idle b_bus", b_bus, 36'h0);

        // Vector table against the reference model
        for (int i = 0; i < NV; i++) begin
            apply(VEC[i]);
            settle();
            for (int g = 0; g < G; g++) begin
                ea = ~VEC[i].oban[g];
                eb = VEC[i].oab[g];
                ai = VEC[i].a[g*W +: W];
                bi = VEC[i].b[g*W +: W];
                sa = m_sa[g];
                sb = m_sb[g];
                ar = '0;
                br = '0;
                for (int k = 0; k < 4; k++) begin
                    ar = VEC[i].aen[g] ? ai : (ea ? sb : m_ha[g]);
                    br = VEC[i].ben[g] ? bi : (eb ? sa : m_hb[g]);
                    if (VEC[i].lab[g] || (VEC[i].cab[g] && !m_cpa[g])) sa = ar;
                    else sa = m_sa[g];
                    if (VEC[i].lba[g] || (VEC[i].cba[g] && !m_cpb[g])) sb = br;
                    else sb = m_sb[g];
                end
                m_sa[g] = sa; m_sb[g] = sb; m_ha[g] = ar; m_hb[g] = br;
                m_cpa[g] = VEC[i].cab[g]; m_cpb[g] = VEC[i].cba[g];

                chk("R4 R7 b_out_en", {35'h0, b_out_en[g]}, {35'h0, eb});
                chk("R5 R7 a_out_en", {35'h0, a_out_en[g]}, {35'h0, ea});
                if (eb) chk("R1 R2 R3 R6 b_out", {18'h0, b_out[g*W +: W]}, {18'h0, sa});
                if (ea) chk("R5 R1 R3 a_out", {18'h0, a_out[g*W +: W]}, {18'h0, sb});
                chk("R8 a_bus", {18'h0, a_bus[g*W +: W]}, {18'h0, ar});
                chk("R8 b_bus", {18'h0, b_bus[g*W +: W]}, {18'h0, br});
            end
        end

        // R1: exact two-cycle latency in transparent mode
        apply('{2'b11, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 36'hA_AAAA_5555, 36'h0});
        settle();
        a_in = 36'h1_0F0F_F0F0;
        @(posedge clk); @(negedge clk);
        chk("R1 one cycle still old", b_out, 36'hA_AAAA_5555);
        @(posedge clk); @(negedge clk);
        chk("R1 two cycles new", b_out, 36'h1_0F0F_F0F0);

        // R9: capture clock already high across reset release is not an edge
        rst_n = 1'b0;
        apply('{2'b11, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b00, 36'h6_1234_4321, 36'h0});
        repeat (2) @(negedge clk);
        chk("R9 reset disables b", {34'h0, b_out_en}, 36'h0);
        chk("R9 reset clears b_bus", b_bus, 36'h0);
        rst_n = 1'b1;
        settle();
        chk("R9 enabled after reset", {34'h0, b_out_en}, 36'h3);
        chk("R9 no capture from high clock", b_out, 36'h0);
        ab_ck = 2'b00;
        settle();
        chk("R2 low clock keeps zero", b_out, 36'h0);
        ab_ck = 2'b11;
        settle();
        chk("R3 first real edge captures", b_out, 36'h6_1234_4321);

        finish_run();
    end

endmodule